// File: doc/BRIEF.md
# Synthesizer Divider Configuration Interface

This block keeps the control words of a frequency synthesizer: a 9-bit feedback divide value, a 3-bit output divider code and a 2-bit test selector. The control words can be written from a parallel pin bus or through a serial shift port. The block drives the divider control outputs and one diagnostic test output.

All strobe, serial and parallel inputs are asynchronous to the block. Each one passes through a synchronizer of `SYNC_STAGES` flops into the system clock domain. Edges are then found on the synchronized levels, so every strobe level must last at least two system clocks.

The two load paths write the same holding registers. The last load event wins. The two strobes behave differently:
- The parallel strobe is active low. It is transparent while low and latches on its rising edge.
- The serial strobe transfers on its rising edge. While it is held high it is transparent to each serial clock edge.

Top module: `synth_cfg_if`

## Requirements
- R1: While `par_load_n` is low, `div_m` and `div_n` follow `par_m` and `par_n`.
- R2: On the rising edge of `par_load_n`, the values on `par_m` and `par_n` are latched. `div_m` and `div_n` then keep those values while the pins change, until the next load event.
- R3: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into a 14-bit register, most significant bit first. After 14 edges the register holds the test selector in bits 13:12, the N code in bits 11:9 and the M value in bits 8:0.
- R4: A rising edge of `ser_load` copies the shift register into the holding registers. After `ser_load` falls, further shifting leaves `div_m`, `div_n` and `tsel` unchanged.
- R5: While `ser_load` is held high, each rising edge of `ser_clk` updates `div_m`, `div_n` and `tsel` with the newly shifted register contents.
- R6: Edges on `ser_clk` while `par_load_n` is low do not change the shift register. A later serial transfer delivers the contents shifted in before parallel mode.
- R7: `test_out` is selected by `tsel`:
  - 00 drives low.
  - 01 drives the synchronized `ser_data`.
  - 10 drives `mdiv_tap`.
  - 11 drives `fout_tap`.
- R8: While `par_load_n` is low, `test_out` is low whatever `tsel` holds.
- R9: Asserting `mr` leaves `div_m`, `div_n` and `tsel` unchanged and forces `test_out` low.
- R10: After `rst_n` is released, the holding registers and the shift register are zero: `div_m`=0, `div_n`=0, `tsel`=0 and `test_out`=0.
- R11: Any 9-bit M value is stored and driven unchanged, including 0 and 511, which lie outside the lockable range 125 to 350.
- R12: A parallel latch leaves the test selector unchanged. A later serial transfer overrides a parallel hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, clears all state |
| mr | input | 1 | Master reset of the synthesizer; only forces the test output low |
| par_load_n | input | 1 | Parallel strobe, transparent low, latches on rise |
| par_m | input | 9 | Parallel M value |
| par_n | input | 3 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial transfer / transparent strobe |
| mdiv_tap | input | 1 | Feedback divider output tap |
| fout_tap | input | 1 | Single-ended synthesizer output copy |
| div_m | output | 9 | M control word to the feedback divider |
| div_n | output | 3 | N control code to the output divider |
| tsel | output | 2 | Held test selector |
| test_out | output | 1 | Diagnostic test output |

## Verification
The bench targets how the two strobes interact, in four cases:
- **Serial clocks during parallel mode.** A design that shifts during parallel mode would later transfer a corrupted frame.
- **Parallel latch and the test selector.** A design that clears the selector on a parallel latch would change `tsel`.
- **Serial strobe held high.** A design that treats `ser_load` only as an edge would leave `div_m` stale during transparent shifting.
- **Shifting after the transfer.** A design that stays transparent after `ser_load` falls would let later bits change the outputs.

The test mux is driven with each selector code while the unselected sources toggle, so a swapped encoding shows up. Out-of-range M values and `mr` are checked to confirm that nothing clamps the M value and that `mr` does not reach the holding registers.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   localparam int TSEL_W = 2;

   typedef enum logic [TSEL_W-1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SDATA = 2'b01,
      TSEL_MDIV  = 2'b10,
      TSEL_FOUT  = 2'b11
   } tsel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cfg_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage[s] <= RST_VAL;
            else if (s == 0) stage[s] <= d;
            else             stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
   parameter int               WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign rise[b] = lvl[b] & ~prev_q[b];
      end
   endgenerate
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
   parameter int FW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          din,
   output logic [FW-1:0] sr_q,
   output logic [FW-1:0] sr_d
);
   generate
      if (FW < 2) begin : g_bad
         $error("cfg_shift frame too short");
      end
   endgenerate

   assign sr_d = shift_en ? {sr_q[FW-2:0], din} : sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

   assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sr_q[0] == $past(din)) && (sr_q[FW-1:1] == $past(sr_q[FW-2:0])));

   assert_noshift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int T_W = 2,
   localparam int FW = M_W + N_W + T_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_rise,
   input  logic [M_W-1:0] par_m_s,
   input  logic [N_W-1:0] par_n_s,
   input  logic           ser_xfer,
   input  logic [FW-1:0]  frame,
   output logic [M_W-1:0] m_q,
   output logic [N_W-1:0] n_q,
   output logic [T_W-1:0] t_q
);
   localparam int N_LO = M_W;
   localparam int T_LO = M_W + N_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         n_q <= '0;
         t_q <= '0;
      end else if (par_rise) begin
         m_q <= par_m_s;
         n_q <= par_n_s;
      end else if (ser_xfer) begin
         m_q <= frame[M_W-1:0];
         n_q <= frame[T_LO-1:N_LO];
         t_q <= frame[FW-1:T_LO];
      end
   end

   assert_par_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      par_rise |=> (m_q == $past(par_m_s)) && (n_q == $past(par_n_s)));

   assert_par_keeps_t_R12: assert property (@(posedge clk) disable iff (!rst_n)
      par_rise |=> $stable(t_q));

   assert_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_xfer && !par_rise) |=> ({t_q, n_q, m_q} == $past(frame)));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_xfer && !par_rise) |=> $stable({t_q, n_q, m_q}));
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
   import synth_cfg_pkg::*;
#(
   parameter int T_W = 2
) (
   input  logic [T_W-1:0] sel,
   input  logic           force_low,
   input  logic           sdata,
   input  logic           mdiv,
   input  logic           fout,
   output logic           test_out
);
   generate
      if (T_W != TSEL_W) begin : g_bad
         $error("cfg_test_mux supports a 2-bit selector only");
      end
   endgenerate

   logic picked;

   always_comb begin
      unique case (tsel_e'(sel))
         TSEL_LOW:   picked = 1'b0;
         TSEL_SDATA: picked = sdata;
         TSEL_MDIV:  picked = mdiv;
         TSEL_FOUT:  picked = fout;
         default:    picked = 1'b0;
      endcase
   end

   assign test_out = picked & ~force_low;
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
   import synth_cfg_pkg::*;
#(
   parameter int M_W         = 9,
   parameter int N_W         = 3,
   parameter int T_W         = TSEL_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mr,
   input  logic           par_load_n,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   input  logic           mdiv_tap,
   input  logic           fout_tap,
   output logic [M_W-1:0] div_m,
   output logic [N_W-1:0] div_n,
   output logic [T_W-1:0] tsel,
   output logic           test_out
);
   localparam int FW   = M_W + N_W + T_W;
   localparam int BUSW = M_W + N_W + 3;

   generate
      if (M_W < 1 || N_W < 1) begin : g_bad
         $error("synth_cfg_if field widths must be positive");
      end
   endgenerate

   // synchronized data bus and parallel strobe
   logic [BUSW-1:0] bus_s;
   logic [M_W-1:0]  par_m_s;
   logic [N_W-1:0]  par_n_s;
   logic            sclk_s, sdat_s, sld_s, pl_s;

   cfg_sync #(.WIDTH(BUSW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n),
      .d({par_m, par_n, ser_clk, ser_data, ser_load}),
      .q(bus_s)
   );

   cfg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pl_sync (
      .clk(clk), .rst_n(rst_n), .d(par_load_n), .q(pl_s)
   );

   assign {par_m_s, par_n_s, sclk_s, sdat_s, sld_s} = bus_s;

   // edges: bit2 serial clock, bit1 serial strobe, bit0 parallel strobe
   logic [2:0] rise;
   cfg_edge #(.WIDTH(3), .RST_VAL(3'b001)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({sclk_s, sld_s, pl_s}), .rise(rise)
   );

   logic sclk_rise, sld_rise, pl_rise;
   assign {sclk_rise, sld_rise, pl_rise} = rise;

   logic          shift_en;
   logic [FW-1:0] sr_q, sr_d;
   assign shift_en = sclk_rise & pl_s;

   cfg_shift #(.FW(FW)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdat_s),
      .sr_q(sr_q), .sr_d(sr_d)
   );

   logic           ser_xfer;
   logic [M_W-1:0] m_q;
   logic [N_W-1:0] n_q;
   logic [T_W-1:0] t_q;
   assign ser_xfer = pl_s & (sld_rise | (sld_s & sclk_rise));

   cfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .par_rise(pl_rise), .par_m_s(par_m_s), .par_n_s(par_n_s),
      .ser_xfer(ser_xfer), .frame(sr_d),
      .m_q(m_q), .n_q(n_q), .t_q(t_q)
   );

   assign div_m = pl_s ? m_q : par_m_s;
   assign div_n = pl_s ? n_q : par_n_s;
   assign tsel  = t_q;

   cfg_test_mux #(.T_W(T_W)) u_mux (
      .sel(t_q), .force_low(~pl_s | mr), .sdata(sdat_s),
      .mdiv(mdiv_tap), .fout(fout_tap), .test_out(test_out)
   );

   assert_par_test_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_s |-> !test_out);

   assert_mr_test_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mr |-> !test_out);

   assert_par_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl_s && $stable(par_m_s)) |-> (div_m == $past(par_m_s)));
endmodule

// File: tb/synth_cfg_if_bench.sv
`timescale 1ns/1ps
module synth_cfg_if_bench;
   logic       clk = 1'b0;
   logic       rst_n, mr, par_load_n, ser_clk, ser_data, ser_load, mdiv_tap, fout_tap;
   logic [8:0] par_m;
   logic [2:0] par_n;
   logic [8:0] div_m;
   logic [2:0] div_n;
   logic [1:0] tsel;
   logic       test_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic [13:0] model_sr = '0;

   always #2.5 clk = ~clk;

   synth_cfg_if u_synth_cfg_if (
      .clk(clk), .rst_n(rst_n), .mr(mr), .par_load_n(par_load_n),
      .par_m(par_m), .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .mdiv_tap(mdiv_tap), .fout_tap(fout_tap),
      .div_m(div_m), .div_n(div_n), .tsel(tsel), .test_out(test_out)
   );

   // parallel vectors {n, m}; each is also the expected held value
   localparam logic [11:0] PVEC [6] = '{
      {3'd0, 9'd125}, {3'd5, 9'd350}, {3'd7, 9'd511},
      {3'd1, 9'd0},   {3'd3, 9'd200}, {3'd6, 9'd256}
   };

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req, input logic [13:0] exp);
      chk(req, {tsel, div_n, div_m}, exp);
   endtask

   task automatic ser_bit(input logic b);
      ser_data = b;
      wclk(3);
      ser_clk = 1'b1;
      wclk(3);
      ser_clk = 1'b0;
      wclk(3);
      if (par_load_n) model_sr = {model_sr[12:0], b};
   endtask

   task automatic ser_frame(input logic [13:0] f);
      for (int i = 13; i >= 0; i--) ser_bit(f[i]);
   endtask

   task automatic ser_pulse();
      ser_load = 1'b1;
      wclk(3);
      ser_load = 1'b0;
      wclk(4);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; mr = 1'b0; par_load_n = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
      ser_load = 1'b0; mdiv_tap = 1'b0; fout_tap = 1'b0; par_m = '0; par_n = '0;
      wclk(4);
      rst_n = 1'b1;
      wclk(4);
      // R10 reset state
      chk_cfg("R10", 14'd0);
      chk("R10 test", test_out, 0);

      // R1/R2/R11 parallel table
      for (int v = 0; v < 6; v++) begin
         par_m = PVEC[v][8:0];
         par_n = PVEC[v][11:9];
         par_load_n = 1'b0;
         wclk(5);
         chk("R1 m", div_m, PVEC[v][8:0]);
         chk("R1 n", div_n, PVEC[v][11:9]);
         chk("R8 test", test_out, 0);
         par_load_n = 1'b1;
         wclk(5);
         par_m = ~PVEC[v][8:0];
         par_n = ~PVEC[v][11:9];
         wclk(5);
         chk("R2 R11 held", {div_n, div_m}, PVEC[v]);
      end

      // R3/R4 serial frame, then transfer
      ser_frame({2'b00, 3'd4, 9'd300});
      chk("R4 no load yet", {div_n, div_m}, PVEC[5]);
      ser_pulse();
      chk_cfg("R3 R4 xfer", {2'b00, 3'd4, 9'd300});
      for (int i = 0; i < 5; i++) ser_bit(1'b1);
      chk_cfg("R4 after fall", {2'b00, 3'd4, 9'd300});

      // R5 strobe held high: transparent
      ser_load = 1'b1;
      wclk(4);
      chk_cfg("R5 rise", model_sr);
      for (int i = 13; i >= 11; i--) ser_bit(14'({2'b01, 3'd2, 9'd137} >> i) & 1'b1);
      chk("R5 mid", div_m, model_sr[8:0]);
      for (int i = 10; i >= 0; i--) ser_bit(14'({2'b01, 3'd2, 9'd137} >> i) & 1'b1);
      chk_cfg("R5 full", {2'b01, 3'd2, 9'd137});
      ser_load = 1'b0;
      wclk(4);

      // R7 code 01: synchronized serial data
      ser_data = 1'b1;
      wclk(4);
      chk("R7 sdata 1", test_out, 1);
      ser_data = 1'b0;
      wclk(4);
      chk("R7 sdata 0", test_out, 0);

      // R6/R12 serial clocks ignored in parallel mode
      par_m = 9'd5; par_n = 3'd1;
      par_load_n = 1'b0;
      wclk(4);
      for (int i = 0; i < 4; i++) ser_bit(1'b1);
      par_load_n = 1'b1;
      wclk(5);
      chk_cfg("R12 par keeps t", {2'b01, 3'd1, 9'd5});
      ser_pulse();
      chk_cfg("R6 R12 frame kept", {2'b01, 3'd2, 9'd137});

      // R7 code 10
      ser_frame({2'b10, 3'd3, 9'd400});
      ser_pulse();
      mdiv_tap = 1'b1; fout_tap = 1'b0; #1;
      chk("R7 mdiv 1", test_out, 1);
      mdiv_tap = 1'b0; fout_tap = 1'b1; #1;
      chk("R7 mdiv 0", test_out, 0);
      // R7 code 11
      ser_frame({2'b11, 3'd6, 9'd250});
      ser_pulse();
      fout_tap = 1'b1; mdiv_tap = 1'b0; #1;
      chk("R7 fout 1", test_out, 1);
      fout_tap = 1'b0; mdiv_tap = 1'b1; #1;
      chk("R7 fout 0", test_out, 0);
      fout_tap = 1'b1;

      // R8 parallel mode forces test low
      par_m = 9'd250; par_n = 3'd6;
      par_load_n = 1'b0;
      wclk(5);
      chk("R8 par low", test_out, 0);
      par_load_n = 1'b1;
      wclk(5);
      chk("R8 restore", test_out, 1);

      // R9 master reset
      mr = 1'b1;
      wclk(4);
      chk("R9 test", test_out, 0);
      chk_cfg("R9 cfg kept", {2'b11, 3'd6, 9'd250});
      mr = 1'b0;
      wclk(2);
      chk("R9 release", test_out, 1);

      // R7 code 00
      ser_frame({2'b00, 3'd0, 9'd128});
      ser_pulse();
      ser_data = 1'b1; mdiv_tap = 1'b1; fout_tap = 1'b1;
      wclk(4);
      chk("R7 low", test_out, 0);

      finish_run();
   end
endmodule